// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit controller datapath. It takes two operands and an opcode and returns the result in the same cycle. It offers binary addition and subtraction, each with and without carry, plus decimal adjust after a BCD addition. It also provides bitwise logic, complement, four rotate forms, increment and decrement. Four test forms drive a skip decision for conditional instruction skipping.

Flag state lives in a status register inside the block. The register holds carry, auxiliary carry, zero and overflow. It also holds two power-management bits: a halt indication and a watchdog expiry indication. The stored carry is the carry input of every carry-consuming operation. Software may write the four arithmetic flags directly. It cannot change the two power-management bits; only the halt, watchdog-clear and watchdog-expiry event inputs move them. Flags update on the clock edge that ends a cycle with `op_valid` high. Result and skip are combinational.

Top module: `alu8_status`

## Requirements
- R1: After reset `status` reads 0x00. The status layout is carry bit 0, auxiliary carry bit 1, zero bit 2, overflow bit 3, halt bit 4 and expiry bit 5. Bits 7:6 always read 0. While `op_valid` is low the flags hold and `skip` is 0.
- R2: ADD (opcode 0) returns a+b and ADC (opcode 1) returns a+b+C, where C is the stored carry. Carry is set by a carry out of bit 7. Auxiliary carry is set by a carry out of bit 3.
- R3: SUB (opcode 2) returns a-b and SBC (opcode 3) returns a-b-(1-C). Carry is set when no borrow occurs. Auxiliary carry is set when the low nibble needs no borrow from the high nibble.
- R4: For opcodes 0 to 3, overflow is set exactly when the carry into bit 7 differs from the carry out of bit 7.
- R5: For opcodes 0 to 3 and the Z-only group of R6, zero is set when the result is 0x00 and cleared otherwise.
- R6: AND (5), OR (6), XOR (7), CPL (8, returns ~a), INC (13) and DEC (14) update only the zero flag.
- R7: RL (9) and RR (10) rotate a by one bit and change no flag. RLC (11) and RRC (12) rotate through the stored carry. The bit shifted out becomes the new carry, and no other flag changes.
- R8: DAA (4) adds 0x06 when a[3:0] > 9 or AC is set. It then adds 0x60 when the high nibble of that sum is above 9, when the sum carried, or when C is set. C becomes 1 if the 0x60 step was applied and 0 otherwise. No other flag changes.
- R9: SZ (15) returns a and skips if it is zero. SNZ (16) returns a and skips if it is nonzero. SIZ (17) returns a+1 and SDZ (18) returns a-1, each skipping if that value is zero. None of the four changes a flag.
- R10: A status write stores `stat_wr_data[3:0]` into the four arithmetic flags and leaves bits 5:4 unchanged. A write takes priority over an operation in the same cycle.
- R11: `halt_evt` sets the halt bit. `wdt_clear_evt` clears it unless `halt_evt` is also high.
- R12: `wdt_timeout_evt` sets the expiry bit. `halt_evt` or `wdt_clear_evt` clears it unless a timeout occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle; enables flag update and skip |
| opcode | input | 5 | Operation select (codes in requirements) |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| stat_wr_en | input | 1 | Direct write to the arithmetic flags |
| stat_wr_data | input | 8 | Write data; bits 3:0 used |
| halt_evt | input | 1 | Halt event |
| wdt_clear_evt | input | 1 | Watchdog clear event |
| wdt_timeout_evt | input | 1 | Watchdog expiry event |
| result | output | 8 | Combinational operation result |
| skip | output | 1 | Skip decision for test opcodes |
| status | output | 8 | Status register |

## Verification
A corrupted stored carry shows up one operation later, in the result of ADC, SBC, RLC or RRC. A carry-consuming opcode therefore follows every flag update, so a stale carry is visible on `result` within two cycles. An arithmetic flag computed wrongly shows on `status` at the edge that ends the operation. A flag mask that is too wide or too narrow also shows there: it disturbs flags that should hold. The power-management bits are visible directly on `status`, one edge after an event or a write.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
        OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
        OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18
    } alu_op_e;

    // Packed so that bit 0 is carry and bit 3 is overflow.
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } aflags_t;

    typedef struct packed {
        logic    to;
        logic    pd;
        aflags_t f;
    } stat_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  logic           acin,
    output logic [W-1:0]   res,
    output aflags_t        fl
);
    localparam int H = W / 2;

    logic           is_sub;
    logic           ci;
    logic [W-1:0]   bx;
    logic [H:0]     lo_sum;
    logic [W-1:0]   low7_sum;
    logic [W:0]     full_sum;

    logic           lo_adj;
    logic           hi_adj;
    logic [W:0]     daa_t;
    logic [W-1:0]   daa_res;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC);
        unique case (op)
            OP_ADC, OP_SBC: ci = cin;
            OP_SUB:         ci = 1'b1;
            default:        ci = 1'b0;
        endcase
        bx       = is_sub ? ~b : b;
        lo_sum   = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, ci};
        low7_sum = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, ci};
        full_sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
    end

    // Decimal adjust: low correction first, then high correction on the sum.
    always_comb begin
        lo_adj  = (a[H-1:0] > H'(9)) || acin;
        daa_t   = {1'b0, a} + (lo_adj ? (W+1)'(6) : '0);
        hi_adj  = (daa_t[W-1:H] > H'(9)) || cin || daa_t[W];
        daa_res = daa_t[W-1:0] + (hi_adj ? W'(8'h60) : '0);
    end

    always_comb begin
        fl = '0;
        if (op == OP_DAA) begin
            res  = daa_res;
            fl.c = hi_adj;
        end else begin
            res   = full_sum[W-1:0];
            fl.c  = full_sum[W];
            fl.ac = lo_sum[H];
            fl.ov = low7_sum[W-1] ^ full_sum[W];
            fl.z  = (full_sum[W-1:0] == '0);
        end
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    always_comb begin
        cout = cin;
        unique case (op)
            OP_AND:          res = a & b;
            OP_OR:           res = a | b;
            OP_XOR:          res = a ^ b;
            OP_CPL:          res = ~a;
            OP_RL:           res = {a[W-2:0], a[W-1]};
            OP_RR:           res = {a[0], a[W-1:1]};
            OP_RLC: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            OP_RRC: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            OP_INC, OP_SIZ:  res = a + W'(1);
            OP_DEC, OP_SDZ:  res = a - W'(1);
            default:         res = a;
        endcase
    end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  aflags_t  upd_mask,
    input  aflags_t  new_flags,
    input  logic     wr_en,
    input  aflags_t  wr_flags,
    input  logic     halt_evt,
    input  logic     wclr_evt,
    input  logic     wto_evt,
    output stat_t    stat_q
);
    stat_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (wr_en)
            stat_d.f = wr_flags;
        else
            stat_d.f = (stat_q.f & ~upd_mask) | (new_flags & upd_mask);

        if (halt_evt)
            stat_d.pd = 1'b1;
        else if (wclr_evt)
            stat_d.pd = 1'b0;

        if (wto_evt)
            stat_d.to = 1'b1;
        else if (halt_evt || wclr_evt)
            stat_d.to = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    opcode,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic          stat_wr_en,
    input  logic [7:0]    stat_wr_data,
    input  logic          halt_evt,
    input  logic          wdt_clear_evt,
    input  logic          wdt_timeout_evt,
    output logic [W-1:0]  result,
    output logic          skip,
    output logic [7:0]    status
);
    alu_op_e       op;
    stat_t         stat_q;
    logic [W-1:0]  arith_res;
    aflags_t       arith_fl;
    logic [W-1:0]  bit_res;
    logic          bit_cout;
    aflags_t       mask_raw;
    aflags_t       nf;
    logic          skip_raw;

    assign op = alu_op_e'(opcode);

    alu8_addsub #(.W(W)) u_addsub (
        .op   (op),
        .a    (op_a),
        .b    (op_b),
        .cin  (stat_q.f.c),
        .acin (stat_q.f.ac),
        .res  (arith_res),
        .fl   (arith_fl)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op   (op),
        .a    (op_a),
        .b    (op_b),
        .cin  (stat_q.f.c),
        .res  (bit_res),
        .cout (bit_cout)
    );

    always_comb begin
        mask_raw = '0;
        nf       = '0;
        skip_raw = 1'b0;
        result   = bit_res;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result   = arith_res;
                nf       = arith_fl;
                mask_raw = '1;
            end
            OP_DAA: begin
                result     = arith_res;
                nf.c       = arith_fl.c;
                mask_raw.c = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: begin
                nf.z       = (bit_res == '0);
                mask_raw.z = 1'b1;
            end
            OP_RL, OP_RR: ;
            OP_RLC, OP_RRC: begin
                nf.c       = bit_cout;
                mask_raw.c = 1'b1;
            end
            OP_SZ, OP_SIZ, OP_SDZ: skip_raw = (bit_res == '0);
            OP_SNZ:                skip_raw = (bit_res != '0);
            default:               result   = '0;
        endcase
    end

    alu8_flagreg u_flagreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_mask  (op_valid ? mask_raw : aflags_t'('0)),
        .new_flags (nf),
        .wr_en     (stat_wr_en),
        .wr_flags  (aflags_t'(stat_wr_data[3:0])),
        .halt_evt  (halt_evt),
        .wclr_evt  (wdt_clear_evt),
        .wto_evt   (wdt_timeout_evt),
        .stat_q    (stat_q)
    );

    assign skip   = op_valid && skip_raw;
    assign status = {2'b00, stat_q};

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [4:0]  opcode,
    input logic        stat_wr_en,
    input logic        halt_evt,
    input logic        wdt_clear_evt,
    input logic        wdt_timeout_evt,
    input logic [7:0]  result,
    input logic        skip,
    input logic [7:0]  status
);
    assert_hi_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:6] == 2'b00);

    assert_skip_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> op_valid);

    assert_rotate_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == 5'd9 || opcode == 5'd10) && !stat_wr_en)
        |=> $stable(status[3:0]));

    assert_and_sets_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 5'd5 && !stat_wr_en)
        |=> (status[2] == ($past(result) == 8'h00)));

    assert_pd_to_protected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !halt_evt && !wdt_clear_evt && !wdt_timeout_evt)
        |=> $stable(status[5:4]));

    assert_halt_sets_pd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |=> status[4]);

    assert_timeout_sets_to_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout_evt |=> status[5]);

endmodule

bind alu8_status alu8_status_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_valid        (op_valid),
    .opcode          (opcode),
    .stat_wr_en      (stat_wr_en),
    .halt_evt        (halt_evt),
    .wdt_clear_evt   (wdt_clear_evt),
    .wdt_timeout_evt (wdt_timeout_evt),
    .result          (result),
    .skip            (skip),
    .status          (status)
);

// File: tb/alu8_status_tb.sv
`timescale 1ns/1ps
module alu8_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] opcode = '0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       stat_wr_en = 1'b0;
    logic [7:0] stat_wr_data = '0;
    logic       halt_evt = 1'b0;
    logic       wdt_clear_evt = 1'b0;
    logic       wdt_timeout_evt = 1'b0;
    logic [7:0] result;
    logic       skip;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    alu8_status u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .stat_wr_en(stat_wr_en),
        .stat_wr_data(stat_wr_data), .halt_evt(halt_evt),
        .wdt_clear_evt(wdt_clear_evt), .wdt_timeout_evt(wdt_timeout_evt),
        .result(result), .skip(skip), .status(status)
    );

    // opcode, a, b, initial flags, expected result, expected skip, expected flags
    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [3:0] init;
        logic [7:0] res;
        logic       skp;
        logic [3:0] flg;
    } vec_t;

    localparam int NV = 31;
    localparam logic [37:0] VEC [0:NV-1] = '{
        {5'd0,  8'h3A, 8'h48, 4'h0, 8'h82, 1'b0, 4'hA},
        {5'd0,  8'hFF, 8'h01, 4'h0, 8'h00, 1'b0, 4'h7},
        {5'd1,  8'h10, 8'h20, 4'h1, 8'h31, 1'b0, 4'h0},
        {5'd1,  8'h7F, 8'h00, 4'h1, 8'h80, 1'b0, 4'hA},
        {5'd2,  8'h50, 8'h20, 4'h0, 8'h30, 1'b0, 4'h3},
        {5'd2,  8'h20, 8'h30, 4'hF, 8'hF0, 1'b0, 4'h2},
        {5'd2,  8'h80, 8'h01, 4'h0, 8'h7F, 1'b0, 4'h9},
        {5'd3,  8'h05, 8'h05, 4'h0, 8'hFF, 1'b0, 4'h0},
        {5'd3,  8'h05, 8'h05, 4'h1, 8'h00, 1'b0, 4'h7},
        {5'd5,  8'hF0, 8'h0F, 4'hB, 8'h00, 1'b0, 4'hF},
        {5'd6,  8'h12, 8'h40, 4'h4, 8'h52, 1'b0, 4'h0},
        {5'd7,  8'hAA, 8'hAA, 4'h1, 8'h00, 1'b0, 4'h5},
        {5'd8,  8'hFF, 8'h00, 4'h2, 8'h00, 1'b0, 4'h6},
        {5'd13, 8'hFF, 8'h00, 4'h0, 8'h00, 1'b0, 4'h4},
        {5'd14, 8'h01, 8'h00, 4'h9, 8'h00, 1'b0, 4'hD},
        {5'd9,  8'h81, 8'h00, 4'h4, 8'h03, 1'b0, 4'h4},
        {5'd10, 8'h01, 8'h00, 4'h0, 8'h80, 1'b0, 4'h0},
        {5'd11, 8'h80, 8'h00, 4'h0, 8'h00, 1'b0, 4'h1},
        {5'd12, 8'h01, 8'h00, 4'h1, 8'h80, 1'b0, 4'h1},
        {5'd12, 8'h02, 8'h00, 4'h3, 8'h81, 1'b0, 4'h2},
        {5'd4,  8'h0A, 8'h00, 4'h0, 8'h10, 1'b0, 4'h0},
        {5'd4,  8'h9A, 8'h00, 4'h0, 8'h00, 1'b0, 4'h1},
        {5'd4,  8'h23, 8'h00, 4'h2, 8'h29, 1'b0, 4'h2},
        {5'd4,  8'h15, 8'h00, 4'h1, 8'h75, 1'b0, 4'h1},
        {5'd15, 8'h00, 8'h00, 4'h0, 8'h00, 1'b1, 4'h0},
        {5'd15, 8'h01, 8'h00, 4'h0, 8'h01, 1'b0, 4'h0},
        {5'd16, 8'h01, 8'h00, 4'h0, 8'h01, 1'b1, 4'h0},
        {5'd16, 8'h00, 8'h00, 4'h0, 8'h00, 1'b0, 4'h0},
        {5'd17, 8'hFF, 8'h00, 4'h8, 8'h00, 1'b1, 4'h8},
        {5'd18, 8'h01, 8'h00, 4'h0, 8'h00, 1'b1, 4'h0},
        {5'd18, 8'h05, 8'h00, 4'h0, 8'h04, 1'b0, 4'h0}
    };

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:                      return "R2";
            5'd2, 5'd3:                      return "R3";
            5'd4:                            return "R8";
            5'd5, 5'd6, 5'd7, 5'd8, 5'd13, 5'd14: return "R6";
            5'd9, 5'd10, 5'd11, 5'd12:       return "R7";
            default:                         return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic write_status(input logic [7:0] d);
        @(negedge clk);
        stat_wr_en   = 1'b1;
        stat_wr_data = d;
        @(negedge clk);
        stat_wr_en   = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        halt_evt        = (which == 0);
        wdt_clear_evt   = (which == 1);
        wdt_timeout_evt = (which == 2);
        @(negedge clk);
        halt_evt = 1'b0; wdt_clear_evt = 1'b0; wdt_timeout_evt = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset status", status, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: op_valid low leaves flags alone and suppresses skip
        opcode = 5'd0; op_a = 8'hFF; op_b = 8'h01; op_valid = 1'b0;
        #1 check("R1", "skip without valid", {7'd0, skip}, 8'h00);
        @(negedge clk);
        check("R1", "flags held without valid", status, 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VEC[i]);
            write_status({4'h0, v.init});
            @(negedge clk);
            opcode = v.op; op_a = v.a; op_b = v.b; op_valid = 1'b1;
            #1;
            check(req_of(v.op), "result", result, v.res);
            check(req_of(v.op), "skip", {7'd0, skip}, {7'd0, v.skp});
            @(negedge clk);
            op_valid = 1'b0;
            // R4 and R5 are covered by the OV/Z bits inside these flag checks
            check(req_of(v.op), "flags R4/R5", status, {4'h0, v.flg});
        end

        // R10: write all ones, only low four bits land, bits 7:6 stay 0 (R1)
        write_status(8'hFF);
        check("R10", "write ff", status, 8'h0F);
        pulse(0);
        check("R11", "halt sets pd", status, 8'h1F);
        write_status(8'h00);
        check("R10", "write keeps pd", status, 8'h10);
        pulse(2);
        check("R12", "timeout sets to", status, 8'h30);
        write_status(8'hC0);
        check("R10", "write keeps pd/to", status, 8'h30);
        pulse(0);
        check("R12", "halt clears to", status, 8'h10);
        pulse(1);
        check("R11", "clear clears pd", status, 8'h00);
        pulse(2);
        check("R12", "timeout alone", status, 8'h20);
        pulse(1);
        check("R12", "clear clears to", status, 8'h00);

        // R11/R12: halt with clear, timeout with halt in the same cycle
        @(negedge clk);
        halt_evt = 1'b1; wdt_clear_evt = 1'b1; wdt_timeout_evt = 1'b1;
        @(negedge clk);
        halt_evt = 1'b0; wdt_clear_evt = 1'b0; wdt_timeout_evt = 1'b0;
        check("R11", "halt beats clear; R12 timeout wins", status, 8'h30);

        // R10: write wins over an ADD in the same cycle
        @(negedge clk);
        opcode = 5'd0; op_a = 8'hFF; op_b = 8'h01; op_valid = 1'b1;
        stat_wr_en = 1'b1; stat_wr_data = 8'h08;
        @(negedge clk);
        op_valid = 1'b0; stat_wr_en = 1'b0;
        check("R10", "write over op", status, 8'h38);

        // R2 with stored carry chaining: ADD sets C, then ADC consumes it
        write_status(8'h00);
        @(negedge clk);
        opcode = 5'd0; op_a = 8'hF0; op_b = 8'h20; op_valid = 1'b1;
        @(negedge clk);
        opcode = 5'd1; op_a = 8'h00; op_b = 8'h00;
        #1 check("R2", "adc uses carry from add", result, 8'h01);
        @(negedge clk);
        op_valid = 1'b0;
        check("R2", "flags after adc", status, 8'h30);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule